// File: doc/BRIEF.md
# Switchable-Depth Arithmetic Pipeline

This block passes 32-bit words through eight short combinational steps. Each step adds a fixed constant and then rotates the word left. A register follows every step. The registers after the odd-numbered steps sit behind a multiplexer, so each of them can be skipped. With all registers in use the pipeline is eight cycles long. With the skippable registers bypassed it is four cycles long. The words that come out are the same in both cases. Only the number of cycles between input and output changes. This lets the surrounding logic trade clock rate against cycle count. At half the clock rate in short mode, the time from input to output is the same as in long mode.

A valid bit moves through the same registers and multiplexers as the data word, so the two never drift apart. Depth can only change while the pipeline is empty. A caller raises a request with the target depth. The block then stops accepting input and lets the words in flight leave. On the first clock edge at which nothing is in flight, it switches every multiplexer to the new depth together. A drained flag shows when no valid word is inside.

Top module: `flexdepth_pipe`

## Requirements
- R1: The output word equals the input after eight steps in order, k = 1..8. Step k first adds (0x9E3779B9 * k) mod 2^32, then rotates left by (2k+1) mod 32 bits.
- R2: In long mode (`half_mode` = 0), a word accepted with `in_valid` high before clock edge t appears on `out_valid`/`out_data` after edge t+7, which is 8 cycles after it was driven.
- R3: In short mode (`half_mode` = 1), the same word appears after edge t+3, which is 4 cycles after it was driven.
- R4: The same input word gives the same output word in both modes.
- R5: Every accepted word leaves exactly once, in order, with no extra outputs. Back-to-back inputs leave back-to-back. `out_valid` is low in the cycle after any cycle in which `drained` is high.
- R6: After `mode_req_valid` is sampled high while `in_ready` is high, `in_ready` is low from the next cycle until the new mode is in force.
- R7: `half_mode` changes only on an edge where `drained` was high. While words are in flight, a pending request does not change `half_mode`.
- R8: During and just after reset, `out_valid` = 0, `half_mode` = 0, `in_ready` = 1 and `drained` = 1.
- R9: A word presented while `in_ready` is low is not accepted and never shows up at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is present |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Input is accepted this cycle |
| mode_req_valid | input | 1 | Request a depth change |
| mode_req_half | input | 1 | Requested depth: 1 short, 0 long |
| out_valid | output | 1 | Output word is present |
| out_data | output | 32 | Transformed word |
| drained | output | 1 | No valid word in any register |
| half_mode | output | 1 | Depth in force: 1 short, 0 long |

## Verification
Each accepted word is logged with the cycle in which it was driven and with the latency that applies in the mode in force. That latency is 8 cycles in long mode and 4 in short mode. The output monitor samples on the falling edge. It checks each word against the log exactly that many cycles later and flags any output that has no log entry. `in_ready` is checked one cycle after a request. `half_mode` is checked for the switch once the last in-flight word has been seen.

// File: rtl/flexdepth_pkg.sv
// Shared definitions for the switchable-depth pipeline.
// Assumes one word width for every step; the step constants and
// rotation amounts are functions of the step index.
package flexdepth_pkg;

    typedef enum logic {
        DEPTH_LONG  = 1'b0,
        DEPTH_SHORT = 1'b1
    } depth_mode_e;

    localparam logic [63:0] STEP_SEED = 64'h0000_0000_9E37_79B9;

    // Rotation applied by step k (1-based) for a word of width w.
    function automatic int unsigned step_rot(input int unsigned k, input int unsigned w);
        return (2 * k + 1) % w;
    endfunction

endpackage

// File: rtl/fd_step.sv
// One combinational step: add a per-step constant, then rotate left.
// Assumes IDX is 1-based and that W is no wider than 64 bits.
module fd_step
    import flexdepth_pkg::*;
#(
    parameter int unsigned W   = 32,
    parameter int unsigned IDX = 1
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    localparam logic [63:0] KFULL = STEP_SEED * 64'(IDX);
    localparam logic [W-1:0] K    = KFULL[W-1:0];
    localparam int unsigned ROT   = step_rot(IDX, W);

    logic [W-1:0]   summed;
    logic [2*W-1:0] doubled;

    // Add the constant, then rotate through a doubled copy.
    always_comb begin
        summed  = a + K;
        doubled = {summed, summed} << ROT;
        y       = doubled[2*W-1:W];
    end
endmodule

// File: rtl/fd_boundary.sv
// Register between two steps, carrying a valid bit and a data word.
// When SKIPPABLE is set and skip is high, the output is the incoming
// value and the register does not hold valid. Otherwise the output is
// the value registered one cycle earlier.
// Assumes skip changes only while the pipeline holds no valid word.
module fd_boundary #(
    parameter int unsigned W         = 32,
    parameter bit          SKIPPABLE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         skip,
    input  logic         a_valid,
    input  logic [W-1:0] a_data,
    output logic         y_valid,
    output logic [W-1:0] y_data,
    output logic         holding
);
    logic         q_valid;
    logic [W-1:0] q_data;
    logic         eff_skip;

    assign eff_skip = SKIPPABLE ? skip : 1'b0;

    // Capture the incoming pair; no valid is held while skipped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else begin
            q_valid <= a_valid & ~eff_skip;
            q_data  <= a_data;
        end
    end

    generate
        if (SKIPPABLE) begin : g_mux
            // Select the live or the registered value.
            always_comb begin
                y_valid = eff_skip ? a_valid : q_valid;
                y_data  = eff_skip ? a_data  : q_data;
            end
        end else begin : g_fixed
            // Always present the registered value.
            always_comb begin
                y_valid = q_valid;
                y_data  = q_data;
            end
        end
    endgenerate

    assign holding = q_valid;
endmodule

// File: rtl/fd_mode_ctrl.sv
// Holds the depth in force and the depth-change handshake.
// A request is latched, input is held off while it is pending, and the
// new depth takes effect on the first edge that sees the pipeline empty.
// Assumes a request that arrives while one is pending may be dropped.
module fd_mode_ctrl
    import flexdepth_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_half,
    input  logic empty,
    output logic short_now,
    output logic pending
);
    depth_mode_e cur_mode;
    depth_mode_e tgt_mode;

    // Latch the request, then apply it once nothing is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mode <= DEPTH_LONG;
            tgt_mode <= DEPTH_LONG;
            pending  <= 1'b0;
        end else if (pending) begin
            if (empty) begin
                cur_mode <= tgt_mode;
                pending  <= 1'b0;
            end
        end else if (req_valid) begin
            tgt_mode <= req_half ? DEPTH_SHORT : DEPTH_LONG;
            pending  <= 1'b1;
        end
    end

    assign short_now = (cur_mode == DEPTH_SHORT);
endmodule

// File: rtl/flexdepth_pipe.sv
// Top: a chain of N_STEPS arithmetic steps, each followed by a register.
// The registers after odd-numbered steps can be skipped, so the chain is
// N_STEPS or N_STEPS/2 cycles long. All skip selects come from one
// registered mode bit, so they switch on the same edge.
// Assumes N_STEPS is even.
module flexdepth_pipe #(
    parameter int unsigned W       = 32,
    parameter int unsigned N_STEPS = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         mode_req_valid,
    input  logic         mode_req_half,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         drained,
    output logic         half_mode
);
    logic               lane_v [N_STEPS+1];
    logic [W-1:0]       lane_d [N_STEPS+1];
    logic [W-1:0]       step_y [N_STEPS];
    logic [N_STEPS-1:0] held;
    logic               short_now;
    logic               pending;

    assign in_ready  = ~pending;
    assign lane_v[0] = in_valid & in_ready;
    assign lane_d[0] = in_data;

    generate
        for (genvar i = 0; i < N_STEPS; i++) begin : g_lane
            fd_step #(.W(W), .IDX(i + 1)) u_step (
                .a (lane_d[i]),
                .y (step_y[i])
            );
            fd_boundary #(.W(W), .SKIPPABLE((i % 2) == 0)) u_reg (
                .clk     (clk),
                .rst_n   (rst_n),
                .skip    (short_now),
                .a_valid (lane_v[i]),
                .a_data  (step_y[i]),
                .y_valid (lane_v[i+1]),
                .y_data  (lane_d[i+1]),
                .holding (held[i])
            );
        end
    endgenerate

    assign drained = ~|held;

    fd_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (mode_req_valid),
        .req_half  (mode_req_half),
        .empty     (drained),
        .short_now (short_now),
        .pending   (pending)
    );

    assign half_mode = short_now;
    assign out_valid = lane_v[N_STEPS];
    assign out_data  = lane_d[N_STEPS];
endmodule

// File: rtl/fd_pipe_checker.sv
// Temporal checks on the pipeline's ports, bound to the top module.
module fd_pipe_checker (
    input logic clk,
    input logic rst_n,
    input logic mode_req_valid,
    input logic in_ready,
    input logic out_valid,
    input logic drained,
    input logic half_mode
);
    assert_reset_state_R8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !half_mode && in_ready && drained));

    assert_req_blocks_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req_valid && in_ready) |=> !in_ready);

    assert_switch_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (half_mode != $past(half_mode)) |-> $past(drained));

    assert_no_phantom_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drained |=> !out_valid);

    assert_mode_held_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !drained |=> $stable(half_mode));
endmodule

bind flexdepth_pipe fd_pipe_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_req_valid (mode_req_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .drained        (drained),
    .half_mode      (half_mode)
);

// File: tb/sim_flexdepth_pipe.sv
module sim_flexdepth_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        mode_req_valid = 1'b0;
    logic        mode_req_half = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        drained;
    logic        half_mode;

    flexdepth_pipe u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .mode_req_valid(mode_req_valid),
        .mode_req_half(mode_req_half), .out_valid(out_valid),
        .out_data(out_data), .drained(drained), .half_mode(half_mode)
    );

    always #5 clk = ~clk;

    localparam int NV = 12;
    localparam logic [31:0] VEC [NV] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000,
        32'hDEAD_BEEF, 32'h1234_5678, 32'hA5A5_A5A5, 32'h5A5A_5A5A,
        32'h6180_0000, 32'h0F0F_00F0, 32'h7FFF_FFFF, 32'hCAFE_F00D
    };

    int cyc = 0;
    int checks = 0, fails = 0;
    int mchecks = 0, mfails = 0;
    logic [31:0] exp_d [256];
    int          exp_t [256];
    int          exp_l [256];
    int head = 0, tail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Independent reference of the eight steps (R1).
    function automatic logic [31:0] ref_word(input logic [31:0] x);
        logic [31:0] v = x;
        for (int k = 1; k <= 8; k++) begin
            int r = (2 * k + 1) % 32;
            v = v + 32'(32'h9E3779B9 * k);
            v = (v << r) | (v >> (32 - r));
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one word for one cycle; log it only if it will be accepted.
    task automatic send(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        if (in_ready) begin
            exp_d[tail % 256] = ref_word(w);
            exp_t[tail % 256] = cyc;
            exp_l[tail % 256] = half_mode ? 4 : 8;
            tail++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Output monitor: data (R1, R4), latency (R2, R3), no extras (R5, R9).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            mchecks++;
            if (head == tail) begin
                mfails++;
                $display("FAIL R5 unexpected output actual=%h expected=none", out_data);
            end else begin
                if (out_data !== exp_d[head % 256]) begin
                    mfails++;
                    $display("FAIL R1/R4 data actual=%h expected=%h", out_data, exp_d[head % 256]);
                end
                if (cyc - exp_t[head % 256] != exp_l[head % 256]) begin
                    mfails++;
                    $display("FAIL %s latency actual=%0d expected=%0d",
                             exp_l[head % 256] == 8 ? "R2" : "R3",
                             cyc - exp_t[head % 256], exp_l[head % 256]);
                end
                head++;
            end
        end
    end

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", checks + mchecks, fails + mfails);
        $finish;
    endtask

    task automatic wait_empty;
        for (int i = 0; i < 40 && head != tail; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(head == tail, "R5", 32'(head), 32'(tail));
    endtask

    task automatic request(input logic half);
        mode_req_valid = 1'b1;
        mode_req_half  = half;
        @(negedge clk);
        mode_req_valid = 1'b0;
        check(!in_ready, "R6", {31'b0, in_ready}, 32'd0);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: state during reset
        check(!out_valid && !half_mode && in_ready && drained, "R8",
              {28'b0, out_valid, half_mode, in_ready, drained}, 32'h3);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !half_mode && in_ready && drained, "R8",
              {28'b0, out_valid, half_mode, in_ready, drained}, 32'h3);

        // Long mode, back to back (R1, R2, R5)
        for (int i = 0; i < NV; i++) send(VEC[i]);
        wait_empty();

        // Switch to short; input offered while held off is dropped (R6, R9)
        request(1'b1);
        send(32'h0BAD_0BAD);
        check(half_mode, "R7", {31'b0, half_mode}, 32'd1);
        wait_empty();

        // Short mode, same table (R3, R4)
        for (int i = 0; i < NV; i++) send(VEC[i]);
        wait_empty();

        // Request while words are in flight (R7)
        for (int i = 0; i < 3; i++) send(VEC[i + 4]);
        request(1'b0);
        check(half_mode, "R7 held in flight", {31'b0, half_mode}, 32'd1);
        for (int i = 0; i < 20 && half_mode; i++) begin
            check(in_ready == 1'b0, "R6 held", {31'b0, in_ready}, 32'd0);
            @(negedge clk);
        end
        check(!half_mode && head == tail, "R7 switch after drain",
              {31'b0, half_mode}, 32'd0);

        // Long mode again, spaced inputs (R2)
        for (int i = 0; i < 4; i++) begin
            send(VEC[i * 3]);
            @(negedge clk);
        end
        wait_empty();
        check(drained, "R5 drained", {31'b0, drained}, 32'd1);
        finish_run();
    end
endmodule